// File: doc/BRIEF.md
# Dual-Mode UART Baud Rate Generator

This block derives the timing strobes for an asynchronous serial port from the system clock. Its first output is a single-cycle strobe at sixteen times the bit rate, which the receiver uses for oversampling. Its second output is a bit strobe at one sixteenth of that rate. Two cascaded stages produce the strobes. The first stage is a pre-divider. It is either a fixed integer divider that divides by 2 or by 3, or a 9-bit phase accumulator that passes a programmable fraction of the clock edges. The second stage is a 13-bit reload counter that divides the pre-divider's pulses by reload+1.

The reload value sits in a holding register. That register accepts a new value only while the generator is stopped. To retune the generator, software clears the run enable, writes the new reload value, and then sets the run enable again. Starting the generator restarts every stage, so the first strobe after start arrives one full period later.

Top module: `uart_brg_gen`

## Requirements
- R1: While `run_en` is 0, `os_tick` and `bit_tick` stay 0. All internal counters return to their idle values, so a later start behaves exactly like a start from reset.
- R2: With `frac_en`=0 and `pre_sel`=0, an `os_tick` pulse occurs every 2×(reload+1) clock cycles.
- R3: With `frac_en`=0 and `pre_sel`=1, an `os_tick` pulse occurs every 3×(reload+1) clock cycles.
- R4: With `frac_en`=1, the pre-divider passes floor(n×S/512) of the first n running clock edges, where S is `frac_step`. A `frac_step` value of 0 counts as S=512, which passes every edge. Each group of reload+1 passed edges produces one `os_tick`. The `pre_sel` input has no effect in this mode.
- R5: A `reload_wr` pulse while `run_en` is 1 is ignored. The period in use, and the value in use after the next start, stay unchanged.
- R6: A `reload_wr` pulse while `run_en` is 0 stores `reload_val`. The first `os_tick` after `run_en` rises comes after one full period. With divider P, it is seen after clock edge P×(reload+1), counting from the first edge at which `run_en` is 1.
- R7: `bit_tick` pulses together with every 16th `os_tick` counted since start, and never without `os_tick`.
- R8: The largest reload value, 8191, divides by 8192. With P=2, the first tick arrives after 16384 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable; 0 stops the generator and clears its stages |
| pre_sel | input | 1 | Integer pre-divider select: 0 divides by 2, 1 divides by 3 |
| frac_en | input | 1 | 1 selects the fractional accumulator in place of the integer pre-divider |
| frac_step | input | 9 | Accumulator increment per clock; 0 counts as 512 |
| reload_wr | input | 1 | Write strobe for the reload holding register |
| reload_val | input | 13 | Reload value; the counter divides by this value plus 1 |
| os_tick | output | 1 | Oversampling strobe, one clock cycle wide |
| bit_tick | output | 1 | Bit strobe, once per 16 oversampling strobes |

## Verification
The assertions assume that reset is held low before the first clock edge. They also assume that `pre_sel`, `frac_en` and `frac_step` are steady whenever the integer-spacing property is checked. A mode change while running is allowed by the checks, but its result is left undefined. The stimulus changes the mode and step inputs only while `run_en` is 0. It issues running writes only to show that they are locked out. It leaves at least one idle cycle after a stopped write before starting again, so every measured period begins from a clean start.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        DIV_OFF  = 2'd0,
        DIV_INTA = 2'd1,
        DIV_INTB = 2'd2,
        DIV_FRAC = 2'd3
    } brg_mode_e;

endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
    import brg_pkg::*;
#(
    parameter int FRAC_W = 9,
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  brg_mode_e         mode,
    input  logic [FRAC_W-1:0] frac_step,
    output logic              pre_en
);
    localparam int CNT_W = (DIV_B > DIV_A) ? $clog2(DIV_B) : $clog2(DIV_A);
    localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);
    localparam logic [FRAC_W:0]  STEP_FULL = (FRAC_W+1)'(1) << FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [FRAC_W:0] step_eff;
    logic [FRAC_W:0] sum;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d     = st_q;
        pre_en   = 1'b0;
        step_eff = (frac_step == '0) ? STEP_FULL : {1'b0, frac_step};
        sum      = {1'b0, st_q.acc} + step_eff;
        lim      = (mode == DIV_INTB) ? LIM_B : LIM_A;
        case (mode)
            DIV_INTA, DIV_INTB: begin
                st_d.acc = '0;
                if (st_q.cnt >= lim) begin
                    pre_en   = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            DIV_FRAC: begin
                st_d.cnt = '0;
                pre_en   = sum[FRAC_W];
                st_d.acc = sum[FRAC_W-1:0];
            end
            default: begin
                st_d.cnt = '0;
                st_d.acc = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2/R3: an integer divider of at least 2 never gives back-to-back pulses
    p_int_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == DIV_INTA || mode == DIV_INTB) && pre_en)
        |=> (mode == DIV_FRAC || !pre_en));

    // R1: a stopped pre-divider produces nothing
    p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DIV_OFF) |-> !pre_en);

endmodule

// File: rtl/brg_reload.sv
module brg_reload #(
    parameter int RELOAD_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                pre_en,
    input  logic                reload_wr,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                os_next,
    output logic                os_tick
);
    typedef struct packed {
        logic [RELOAD_W-1:0] hold;
        logic [RELOAD_W-1:0] cnt;
        logic                os;
    } rl_state_t;

    rl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.os = 1'b0;
        if (reload_wr && !run_en) st_d.hold = reload_val;
        if (!run_en) begin
            st_d.cnt = reload_wr ? reload_val : st_q.hold;
        end else if (pre_en) begin
            if (st_q.cnt == '0) begin
                st_d.os  = 1'b1;
                st_d.cnt = st_q.hold;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        os_next = st_d.os;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign os_tick = st_q.os;

    logic [RELOAD_W-1:0] hold_q;
    assign hold_q = st_q.hold;

    // R5: the holding register is frozen while running
    p_hold_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(hold_q));

    // R6: every strobe follows a pre-divider pulse
    p_tick_after_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> $past(pre_en));

endmodule

// File: rtl/brg_phase.sv
module brg_phase #(
    parameter int PHASE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic os_next,
    output logic bit_tick
);
    localparam logic [PHASE_W-1:0] PH_LAST = '1;

    typedef struct packed {
        logic [PHASE_W-1:0] ph;
        logic               bt;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.bt = 1'b0;
        if (!run_en) begin
            st_d.ph = '0;
        end else if (os_next) begin
            st_d.bt = (st_q.ph == PH_LAST);
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick = st_q.bt;

    logic [PHASE_W-1:0] phase_q;
    assign phase_q = st_q.ph;

    // R7: a bit strobe is seen just after the phase wrapped to zero
    p_bit_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (phase_q == '0));

endmodule

// File: rtl/uart_brg_gen.sv
module uart_brg_gen
    import brg_pkg::*;
#(
    parameter int RELOAD_W = 13,
    parameter int FRAC_W   = 9,
    parameter int PHASE_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                pre_sel,
    input  logic                frac_en,
    input  logic [FRAC_W-1:0]   frac_step,
    input  logic                reload_wr,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                os_tick,
    output logic                bit_tick
);
    brg_mode_e mode;
    logic      pre_en;
    logic      os_next;

    always_comb begin
        if (!run_en)      mode = DIV_OFF;
        else if (frac_en) mode = DIV_FRAC;
        else if (pre_sel) mode = DIV_INTB;
        else              mode = DIV_INTA;
    end

    brg_prescale #(.FRAC_W(FRAC_W), .DIV_A(2), .DIV_B(3)) i_pre (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .frac_step(frac_step), .pre_en(pre_en)
    );

    brg_reload #(.RELOAD_W(RELOAD_W)) i_rl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_en(pre_en),
        .reload_wr(reload_wr), .reload_val(reload_val),
        .os_next(os_next), .os_tick(os_tick)
    );

    brg_phase #(.PHASE_W(PHASE_W)) i_ph (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .os_next(os_next), .bit_tick(bit_tick)
    );

    // R1: stopping silences both outputs from the next cycle
    p_quiet_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!os_tick && !bit_tick));

    // R7: the bit strobe always coincides with an oversampling strobe
    p_bit_with_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

endmodule

// File: tb/test_uart_brg_gen.sv
module test_uart_brg_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, pre_sel = 1'b0, frac_en = 1'b0, reload_wr = 1'b0;
    logic [8:0]  frac_step = '0;
    logic [12:0] reload_val = '0;
    logic        os_tick, bit_tick;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_div = 0, m_acc = 0, m_hold = 0, m_cnt = 0, m_ph = 0;
    bit m_os = 0, m_bit = 0;

    always #2 clk = ~clk;

    uart_brg_gen i_uart_brg_gen (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_sel(pre_sel),
        .frac_en(frac_en), .frac_step(frac_step), .reload_wr(reload_wr),
        .reload_val(reload_val), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always @(posedge clk) begin
        bit pulse;
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_acc = 0; m_hold = 0; m_cnt = 0; m_ph = 0; m_os = 0; m_bit = 0;
        end else if (!run_en) begin
            m_div = 0; m_acc = 0; m_ph = 0; m_os = 0; m_bit = 0;
            if (reload_wr) m_hold = reload_val;
            m_cnt = m_hold;
        end else begin
            pulse = 0;
            if (frac_en) begin
                m_acc += (frac_step == 0) ? 512 : frac_step;
                if (m_acc >= 512) begin pulse = 1; m_acc -= 512; end
            end else begin
                m_div++;
                if (m_div == (pre_sel ? 3 : 2)) begin pulse = 1; m_div = 0; end
            end
            m_os = 0; m_bit = 0;
            if (pulse) begin
                if (m_cnt == 0) begin m_os = 1; m_cnt = m_hold; end
                else m_cnt--;
            end
            if (m_os) begin
                m_bit = (m_ph == 15);
                m_ph = (m_ph + 1) % 16;
            end
        end
        #1;
        if (rst_n) begin
            n_chk++;
            if (os_tick !== m_os || bit_tick !== m_bit) begin
                n_bad++;
                $display("FAIL %s cycle %0d: os/bit actual %b%b expected %b%b",
                         cur_req, cyc, os_tick, bit_tick, m_os, m_bit);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic segment(string req, bit psel, bit fen, int step, int rl,
                           int ncyc, int exp_os, int exp_bit, int wr_at, int wr_val);
        int c_os = 0, c_bit = 0;
        cur_req = req;
        @(posedge clk); #1;
        run_en = 0; pre_sel = psel; frac_en = fen; frac_step = 9'(step);
        reload_wr = 1; reload_val = 13'(rl);
        @(posedge clk); #1;
        reload_wr = 0;
        @(posedge clk); #1;
        run_en = 1;
        for (int i = 1; i <= ncyc; i++) begin
            reload_wr = (i == wr_at);
            reload_val = 13'(wr_val);
            @(posedge clk); #1;
            if (os_tick) c_os++;
            if (bit_tick) c_bit++;
        end
        reload_wr = 0;
        check({req, " os count"}, c_os, exp_os);
        check({req, " bit count"}, c_bit, exp_bit);
    endtask

    initial begin
        int quiet;
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset os", int'(os_tick), 0);
        check("R1 reset bit", int'(bit_tick), 0);
        rst_n = 1;
        segment("R2", 0, 0, 0, 3, 200, 25, 1, 0, 0);
        segment("R6", 0, 0, 0, 3, 8, 1, 0, 0, 0);
        segment("R3", 1, 0, 0, 4, 300, 20, 1, 0, 0);
        segment("R5", 0, 0, 0, 3, 200, 25, 1, 50, 0);
        // stop: no ticks for a while
        cur_req = "R1";
        @(posedge clk); #1; run_en = 0;
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (os_tick || bit_tick) quiet++;
        end
        check("R1 stopped ticks", quiet, 0);
        segment("R4", 0, 1, 128, 0, 400, 100, 6, 0, 0);
        segment("R4", 1, 1, 0, 1, 128, 64, 4, 0, 0);
        segment("R4", 0, 1, 384, 2, 384, 96, 6, 0, 0);
        segment("R7", 0, 0, 0, 0, 64, 32, 2, 0, 0);
        segment("R8", 0, 0, 0, 8191, 16400, 1, 0, 0, 0);
        @(posedge clk); #1; run_en = 0;
        repeat (2) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule